// File: doc/BRIEF.md
# Serial Flash Read Responder with Byte-Wide Output Mode

This block is the device side of a serial flash that answers read requests on a four-wire serial bus. The bus has a chip select, a serial clock, a data input and a data output. The host lowers chip select and sends an instruction byte. For a read, it follows this with a 24-bit address. The block then streams bytes from its internal array, starting at that address. The stream continues until chip select rises.

By default the data leaves one bit per clock on the serial output. A mode command switches the block to byte-wide operation. In that mode every clock presents a whole byte on an 8-bit output bus, and the byte order is the same as in serial mode. The mode lasts across any number of transactions. Only a leave command or a reset ends it.

Inputs are sampled on the rising clock edge and outputs change on the falling edge. A simple write port fills the array before use.

Top module: `sfr_read_resp`

## Requirements
- R1: After reset, both output enables (`so_oe`, `par_oe`) are low and the block is in serial mode.
- R2: Instruction 03h starts a read. The next 24 bits are the address, most significant bit first. The first data bit is driven after the falling edge that follows the 32nd rising edge of the transaction.
- R3: In serial mode, data leaves on `so` one bit per clock. The most significant bit comes first and `so` changes on the falling edge. Each following byte comes from the next address.
- R4: The address is taken modulo the array depth, so bits above the index width are ignored. After the last array location, the next byte comes from location zero.
- R5: Instruction 55h selects byte-wide mode. A read in this mode places one full byte on `par_q` at each falling edge, with `par_oe` high and `so_oe` low.
- R6: Byte-wide mode stays selected across later chip-select cycles, including read transactions.
- R7: Instruction 45h returns the block to serial mode.
- R8: Reset returns the block to serial mode.
- R9: Both output enables stay low during the instruction and address phases.
- R10: Raising `cs_n` at any point drops both output enables at once. The next transaction then starts decoding from its first bit. The mode is not changed.
- R11: An unrecognised instruction makes the block ignore all further input until `cs_n` rises. No output is enabled and the mode is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial clock; rising edge samples, falling edge drives |
| rst | input | 1 | Synchronous active-high reset (power cycle) |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| ld_we | input | 1 | Array preload write enable |
| ld_addr | input | IDX_W | Array preload location |
| ld_data | input | 8 | Array preload byte |
| so | output | 1 | Serial data out, high impedance when `so_oe` is low |
| so_oe | output | 1 | Serial output enable |
| par_q | output | 8 | Byte-wide data out, high impedance when `par_oe` is low |
| par_oe | output | 1 | Byte-wide output enable |

## Verification
The hardest situation to reach is a transaction that deviates partway through. Examples are chip select rising in the middle of the address, and an unknown opcode followed by bits that spell the mode command. Either case can leave stale decoder state behind unnoticed. The stimulus aborts a read after 20 bits and then issues a full read, which must decode from bit zero. It sends A5h followed by 55h, and a later serial read must show the mode unchanged. Mode persistence is reached by chaining several byte-wide reads, one of which runs through the array wrap, before leaving by command and again by reset.

// File: rtl/sfr_pkg.sv
`timescale 1ns/1ps
package sfr_pkg;
    localparam int unsigned ADDR_BITS       = 24;
    localparam int unsigned BYTE_BITS       = 8;
    // Highest serial clock allowed while byte-wide output is selected.
    localparam int unsigned PAR_FSCK_MAX_HZ = 6_000_000;

    typedef enum logic [7:0] {
        OP_READ    = 8'h03,
        OP_WIDE_ON = 8'h55,
        OP_WIDE_OFF= 8'h45
    } op_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_ADDR,
        PH_DATA,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic       started;
        logic [2:0] bidx;
        logic [7:0] cur;
    } out_st_s;

    function automatic logic [2:0] next_bidx(input logic [2:0] b);
        return b - 3'd1;
    endfunction
endpackage

// File: rtl/sfr_array.sv
`timescale 1ns/1ps
module sfr_array #(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             sck,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [7:0]       rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge sck) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sfr_cmd_decoder.sv
`timescale 1ns/1ps
module sfr_cmd_decoder
    import sfr_pkg::*;
#(
    parameter int IDX_W = 8,
    localparam int SH_W = (IDX_W > 8) ? IDX_W : 8,
    localparam int CNT_W = 5
) (
    input  logic             sck,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             si,
    output phase_e           phase_o,
    output logic             wide_o,
    output logic [IDX_W-1:0] start_idx_o
);
    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SH_W-1:0]  sh_q;
    logic             wide_q;
    logic [7:0]       op_w;

    assign op_w = {sh_q[6:0], si};

    always_ff @(posedge sck) begin
        if (rst) begin
            phase_q <= PH_CMD;
            cnt_q   <= '0;
            sh_q    <= '0;
            wide_q  <= 1'b0;
        end else if (cs_n) begin
            phase_q <= PH_CMD;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_CMD: begin
                    sh_q  <= {sh_q[SH_W-2:0], si};
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(BYTE_BITS - 1)) begin
                        cnt_q <= '0;
                        if (op_w == OP_READ) begin
                            phase_q <= PH_ADDR;
                        end else if (op_w == OP_WIDE_ON) begin
                            wide_q  <= 1'b1;
                            phase_q <= PH_SKIP;
                        end else if (op_w == OP_WIDE_OFF) begin
                            wide_q  <= 1'b0;
                            phase_q <= PH_SKIP;
                        end else begin
                            phase_q <= PH_SKIP;
                        end
                    end
                end
                PH_ADDR: begin
                    sh_q  <= {sh_q[SH_W-2:0], si};
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNT_W'(ADDR_BITS - 1)) begin
                        cnt_q   <= '0;
                        phase_q <= PH_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    assign phase_o     = phase_q;
    assign wide_o      = wide_q;
    assign start_idx_o = sh_q[IDX_W-1:0];

    p_abort_clears_r10: assert property (@(posedge sck) disable iff (rst)
        cs_n |=> (phase_q == PH_CMD && cnt_q == '0));
    p_addr_len_r2: assert property (@(posedge sck) disable iff (rst)
        (phase_q == PH_ADDR && cnt_q == CNT_W'(ADDR_BITS - 1) && !cs_n) |=> phase_q == PH_DATA);
    p_reset_serial_r8: assert property (@(posedge sck)
        rst |=> !wide_q);
    p_mode_hold_r6: assert property (@(posedge sck) disable iff (rst)
        (phase_q != PH_CMD || cs_n) |=> $stable(wide_q));
endmodule

// File: rtl/sfr_out_stage.sv
`timescale 1ns/1ps
module sfr_out_stage
    import sfr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             sck,
    input  logic             rst,
    input  logic             cs_n,
    input  phase_e           phase,
    input  logic             wide,
    input  logic [IDX_W-1:0] start_idx,
    input  logic [7:0]       rd_data,
    output logic [IDX_W-1:0] rd_addr,
    output logic             so_bit,
    output logic [7:0]       wide_byte,
    output logic             so_en,
    output logic             wide_en
);
    out_st_s          st_q;
    logic [IDX_W-1:0] ptr_q;

    assign rd_addr = st_q.started ? ptr_q : start_idx;

    always_ff @(negedge sck) begin
        if (rst || phase != PH_DATA) begin
            st_q  <= '{started: 1'b0, bidx: 3'd7, cur: 8'h00};
            ptr_q <= '0;
        end else if (!st_q.started) begin
            st_q  <= '{started: 1'b1, bidx: 3'd7, cur: rd_data};
            ptr_q <= start_idx + 1'b1;
        end else if (wide || st_q.bidx == 3'd0) begin
            st_q.cur  <= rd_data;
            st_q.bidx <= 3'd7;
            ptr_q     <= ptr_q + 1'b1;
        end else begin
            st_q.bidx <= next_bidx(st_q.bidx);
        end
    end

    assign so_bit    = st_q.cur[st_q.bidx];
    assign wide_byte = st_q.cur;
    assign so_en     = st_q.started && !cs_n && !wide;
    assign wide_en   = st_q.started && !cs_n && wide;

    p_quiet_outside_data_r9: assert property (@(posedge sck) disable iff (rst)
        (phase != PH_DATA) |-> !(so_en || wide_en));
endmodule

// File: rtl/sfr_read_resp.sv
`timescale 1ns/1ps
module sfr_read_resp
    import sfr_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             sck,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             si,
    input  logic             ld_we,
    input  logic [IDX_W-1:0] ld_addr,
    input  logic [7:0]       ld_data,
    output logic             so,
    output logic             so_oe,
    output logic [7:0]       par_q,
    output logic             par_oe
);
    phase_e           phase_w;
    logic             wide_w;
    logic [IDX_W-1:0] start_idx_w;
    logic [IDX_W-1:0] rd_addr_w;
    logic [7:0]       rd_data_w;
    logic             so_bit_w;
    logic [7:0]       wide_byte_w;

    sfr_cmd_decoder #(.IDX_W(IDX_W)) dec_i (
        .sck(sck), .rst(rst), .cs_n(cs_n), .si(si),
        .phase_o(phase_w), .wide_o(wide_w), .start_idx_o(start_idx_w)
    );

    sfr_array #(.DEPTH(DEPTH)) arr_i (
        .sck(sck), .we(ld_we), .waddr(ld_addr), .wdata(ld_data),
        .raddr(rd_addr_w), .rdata(rd_data_w)
    );

    sfr_out_stage #(.IDX_W(IDX_W)) out_i (
        .sck(sck), .rst(rst), .cs_n(cs_n), .phase(phase_w), .wide(wide_w),
        .start_idx(start_idx_w), .rd_data(rd_data_w), .rd_addr(rd_addr_w),
        .so_bit(so_bit_w), .wide_byte(wide_byte_w),
        .so_en(so_oe), .wide_en(par_oe)
    );

    assign so    = so_oe  ? so_bit_w    : 1'bz;
    assign par_q = par_oe ? wide_byte_w : 8'bz;
endmodule

// File: tb/sfr_read_resp_tb.sv
`timescale 1ns/1ps
module sfr_read_resp_tb_top;
    localparam int DEPTH = 256;
    localparam int IDX_W = $clog2(DEPTH);

    logic sck = 1'b0;
    logic rst, cs_n, si, ld_we;
    logic [IDX_W-1:0] ld_addr;
    logic [7:0] ld_data;
    logic so, so_oe, par_oe;
    logic [7:0] par_q;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] mref [DEPTH];

    always #5 sck = ~sck;

    sfr_read_resp #(.DEPTH(DEPTH)) dut_i (
        .sck(sck), .rst(rst), .cs_n(cs_n), .si(si),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .so(so), .so_oe(so_oe), .par_q(par_q), .par_oe(par_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input string req);
        for (int i = 7; i >= 0; i--) begin
            si = b[i];
            @(posedge sck); #2;
            chk(!so_oe && !par_oe, req, {so_oe, par_oe}, 0);
        end
    endtask

    task automatic cs_up(input string req);
        cs_n = 1'b1;
        #1;
        chk(!so_oe && !par_oe, req, {so_oe, par_oe}, 0);
        repeat (2) begin @(posedge sck); #2; end
    endtask

    task automatic begin_read(input logic [23:0] a);
        cs_n = 1'b0;
        send_byte(8'h03, "R9 opcode phase quiet");
        send_byte(a[23:16], "R9 address phase quiet");
        send_byte(a[15:8],  "R9 address phase quiet");
        send_byte(a[7:0],   "R9 address phase quiet");
    endtask

    task automatic read_serial(input logic [23:0] a, input int nbytes, input string req);
        int base;
        base = int'(a) % DEPTH;
        begin_read(a);
        for (int k = 0; k < nbytes * 8; k++) begin
            logic expb;
            @(negedge sck); #2;
            expb = mref[(base + k / 8) % DEPTH][7 - (k % 8)];
            chk(so_oe && !par_oe && so == expb, req, {so_oe, par_oe, so}, {1'b1, 1'b0, expb});
        end
        cs_up("R10 oe drop on cs rise");
    endtask

    task automatic read_wide(input logic [23:0] a, input int nbytes, input string req);
        int base;
        base = int'(a) % DEPTH;
        begin_read(a);
        for (int k = 0; k < nbytes; k++) begin
            logic [7:0] expv;
            @(negedge sck); #2;
            expv = mref[(base + k) % DEPTH];
            chk(par_oe && !so_oe && par_q == expv, req, {so_oe, par_oe, par_q}, {2'b01, expv});
        end
        cs_up("R10 oe drop on cs rise");
    endtask

    task automatic mode_cmd(input logic [7:0] op, input string req);
        cs_n = 1'b0;
        send_byte(op, req);
        cs_up(req);
    endtask

    task automatic do_reset();
        rst = 1'b1; cs_n = 1'b1;
        repeat (3) begin @(posedge sck); #2; end
        rst = 1'b0;
        @(posedge sck); #2;
        chk(!so_oe && !par_oe, "R1 outputs off after reset", {so_oe, par_oe}, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cs_n = 1'b1; si = 1'b0; ld_we = 1'b0; ld_addr = '0; ld_data = '0;
        $display("Byte-wide mode clock limit %0d Hz", sfr_pkg::PAR_FSCK_MAX_HZ);
        @(posedge sck); #2;
        do_reset();

        // preload array with a computed pattern
        for (int i = 0; i < DEPTH; i++) begin
            mref[i] = 8'((i * 37 + 11) ^ (i >> 3));
            ld_we = 1'b1; ld_addr = IDX_W'(i); ld_data = mref[i];
            @(posedge sck); #2;
        end
        ld_we = 1'b0;
        repeat (2) begin @(posedge sck); #2; end

        // R1 R2 R3: serial read after reset
        read_serial(24'h000010, 3, "R2 R3 serial stream");
        // R4: wrap and upper bits ignored
        read_serial(24'h0000FE, 4, "R4 wrap to zero");
        read_serial(24'h123405, 2, "R4 upper address bits ignored");

        // R10: abort mid-address, then a clean read
        cs_n = 1'b0;
        send_byte(8'h03, "R9 opcode phase quiet");
        send_byte(8'h00, "R9 address phase quiet");
        for (int i = 0; i < 4; i++) begin si = 1'b1; @(posedge sck); #2; end
        cs_up("R10 abort drops outputs");
        read_serial(24'h000040, 2, "R10 decode restarts after abort");

        // R11: unknown opcode followed by a mode-on pattern
        cs_n = 1'b0;
        send_byte(8'hA5, "R11 unknown opcode no output");
        send_byte(8'h55, "R11 bits ignored after unknown opcode");
        send_byte(8'h03, "R11 bits ignored after unknown opcode");
        cs_up("R11 unknown opcode no output");
        read_serial(24'h000020, 1, "R11 mode unchanged");

        // R5 R6: byte-wide mode, persistent over several transactions
        mode_cmd(8'h55, "R5 mode command quiet");
        read_wide(24'h000030, 5, "R5 byte per clock");
        read_wide(24'h0000FD, 6, "R6 persists, wraps");
        mode_cmd(8'hA5, "R6 unknown opcode quiet");
        read_wide(24'h000080, 3, "R6 persists after other cycles");

        // R7: leave by command
        mode_cmd(8'h45, "R7 leave command quiet");
        read_serial(24'h000031, 2, "R7 serial after leave command");

        // R8: leave by reset
        mode_cmd(8'h55, "R5 mode command quiet");
        read_wide(24'h000007, 2, "R5 byte per clock");
        do_reset();
        read_serial(24'h000007, 2, "R8 serial after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule